// File: doc/BRIEF.md
# Multi-Cycle Coprocessor Array Controller

This block sits between a host processor and a reconfigurable array that serves as a multi-cycle coprocessor. The host drives one command per cycle on a small command port. There are four commands. The first makes a named configuration resident. The second pushes an operand pair into the array. The third fetches the array result. The fourth starts the array for a given number of cycles. While the array runs, the controller raises a stall output that holds the processor. It counts the requested cycles down to zero and then releases the processor.

Configuration residency goes through a small cache of configuration tags, with least-recently-used replacement. A tag found in the cache becomes resident at once. A tag that is not found is loaded over a fixed latency, and the controller reports that load on a load output. The array datapath, the coherence logic and the bitstream storage lie outside this block. The array result arrives on an input bus and is sampled when a read completes.

Top module: `coproc_array_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, busy, stall, cfg_load, arr_wr_en, rd_valid and err are all low.
- R2: A configure command (cmd_op = 0) whose tag is in the cache raises busy for exactly one cycle, starting the cycle after acceptance, and leaves cfg_load low. cfg_tag shows the requested tag.
- R3: A configure command whose tag is not in the cache raises busy and cfg_load together for exactly LOAD_LAT cycles (16 by default), starting the cycle after acceptance. cfg_tag shows the requested tag.
- R4: The cache holds NWAYS tags (4 by default). On a miss it fills an empty way first. When no way is empty, it evicts the tag that was least recently configured, where both hits and misses count as use.
- R5: A move-to command (cmd_op = 1) pulses arr_wr_en for one cycle, the cycle after acceptance. In that cycle arr_a and arr_b carry the two operands cmd_a and cmd_b.
- R6: A move-from command (cmd_op = 2) issued while the array is idle pulses rd_valid for one cycle, the cycle after acceptance. rd_data holds arr_result as sampled at the acceptance edge.
- R7: A start command (cmd_op = 3) with count N, issued while a configuration is resident, holds stall high for exactly N+1 cycles, starting the cycle after acceptance.
- R8: A move-from command issued while stall is high gives no rd_valid during the run. rd_valid pulses in the first cycle with stall low, and rd_data carries arr_result as sampled at the edge where stall falls.
- R9: A start command issued when no configuration is resident does not raise stall and sets err the cycle after acceptance. The next accepted command clears err.
- R10: While busy or stall is high, the controller ignores every command except a move-from during a run. An ignored command produces no write pulse, no busy, and no change to stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 configure, 1 move-to, 2 move-from, 3 start |
| cmd_tag | input | TAG_W | Configuration tag for configure |
| cmd_cnt | input | CNT_W | Run length N for start |
| cmd_a | input | DW | First operand for move-to |
| cmd_b | input | DW | Second operand for move-to |
| arr_result | input | DW | Result bus from the array |
| busy | output | 1 | Configuration step in progress |
| stall | output | 1 | Processor held; array running |
| cfg_load | output | 1 | Configuration load in progress after a miss |
| cfg_tag | output | TAG_W | Tag of the resident or loading configuration |
| arr_wr_en | output | 1 | Operand write strobe to the array |
| arr_a | output | DW | First operand to the array |
| arr_b | output | DW | Second operand to the array |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DW | Read result |
| err | output | 1 | Start refused for lack of a resident configuration |

## Verification
A corrupted cache age or tag shows up at the ports on the next configure of the affected tag. A hit turns into a 16-cycle load, or a load turns into a one-cycle step, so the busy length exposes the fault within one command. A run counter that is off by one changes the stall length in the same run. A pending-read flag that is lost or stuck shows up as a missing or extra rd_valid in the first cycle after stall falls. The bench therefore measures busy and stall lengths cycle by cycle and compares them against a queue-based model of the replacement order.

// File: rtl/coproc_array_ctrl.sv
module coproc_array_ctrl #(
  parameter int DW       = 32,
  parameter int TAG_W    = 8,
  parameter int CNT_W    = 16,
  parameter int NWAYS    = 4,
  parameter int LOAD_LAT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic [CNT_W-1:0] cmd_cnt,
  input  logic [DW-1:0]    cmd_a,
  input  logic [DW-1:0]    cmd_b,
  input  logic [DW-1:0]    arr_result,
  output logic             busy,
  output logic             stall,
  output logic             cfg_load,
  output logic [TAG_W-1:0] cfg_tag,
  output logic             arr_wr_en,
  output logic [DW-1:0]    arr_a,
  output logic [DW-1:0]    arr_b,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             err
);
  localparam int AW = (NWAYS > 1) ? $clog2(NWAYS) : 1;
  localparam int LW = $clog2(LOAD_LAT + 1);
  localparam logic [1:0] OP_CFG = 2'd0, OP_MTO = 2'd1, OP_MFR = 2'd2, OP_RUN = 2'd3;

  logic [TAG_W-1:0] way_tag [NWAYS];
  logic             way_vld [NWAYS];
  logic [AW-1:0]    way_age [NWAYS];

  logic [LW-1:0]    lcnt;
  logic [CNT_W-1:0] cnt;
  logic             res_vld, pend;

  wire idle   = !busy && !stall;
  wire acc    = cmd_valid && idle;
  wire cfg_go = acc && cmd_op == OP_CFG;
  wire mto_go = acc && cmd_op == OP_MTO;
  wire mfr_go = acc && cmd_op == OP_MFR;
  wire run_go = acc && cmd_op == OP_RUN;
  wire mfr_rn = cmd_valid && stall && cmd_op == OP_MFR;
  wire done   = stall && cnt == '0;

  logic          hit, found;
  logic [AW-1:0] hit_idx, vic_idx, touch;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    found = 1'b0;
    vic_idx = '0;
    for (int i = 0; i < NWAYS; i++)
      if (way_vld[i] && way_tag[i] == cmd_tag) begin
        hit = 1'b1;
        hit_idx = AW'(i);
      end
    for (int i = 0; i < NWAYS; i++)
      if (!way_vld[i] && !found) begin
        found = 1'b1;
        vic_idx = AW'(i);
      end
    if (!found)
      for (int i = 0; i < NWAYS; i++)
        if (way_age[i] == AW'(NWAYS - 1)) vic_idx = AW'(i);
    touch = hit ? hit_idx : vic_idx;
  end

  generate
    for (genvar g = 0; g < NWAYS; g++) begin : g_way
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          way_tag[g] <= '0;
          way_vld[g] <= 1'b0;
          way_age[g] <= AW'(g);
        end else if (cfg_go) begin
          if (touch == AW'(g)) begin
            way_age[g] <= '0;
            way_vld[g] <= 1'b1;
            way_tag[g] <= cmd_tag;
          end else if (way_age[g] < way_age[touch]) begin
            way_age[g] <= way_age[g] + 1'b1;
          end
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cfg_load <= 1'b0;
      lcnt <= '0;
      cfg_tag <= '0;
      res_vld <= 1'b0;
    end else if (cfg_go) begin
      busy <= 1'b1;
      cfg_load <= !hit;
      lcnt <= hit ? '0 : LW'(LOAD_LAT - 1);
      cfg_tag <= cmd_tag;
      res_vld <= hit;
    end else if (busy) begin
      if (lcnt == '0) begin
        busy <= 1'b0;
        cfg_load <= 1'b0;
        res_vld <= 1'b1;
      end else begin
        lcnt <= lcnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stall <= 1'b0;
      cnt <= '0;
    end else if (run_go && res_vld) begin
      stall <= 1'b1;
      cnt <= cmd_cnt;
    end else if (done) begin
      stall <= 1'b0;
    end else if (stall) begin
      cnt <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err <= 1'b0;
      arr_wr_en <= 1'b0;
      arr_a <= '0;
      arr_b <= '0;
      rd_valid <= 1'b0;
      rd_data <= '0;
      pend <= 1'b0;
    end else begin
      if (acc) err <= run_go && !res_vld;
      arr_wr_en <= mto_go;
      if (mto_go) begin
        arr_a <= cmd_a;
        arr_b <= cmd_b;
      end
      rd_valid <= mfr_go || (done && (pend || mfr_rn));
      if (mfr_go || (done && (pend || mfr_rn))) rd_data <= arr_result;
      if (done) pend <= 1'b0;
      else if (mfr_rn) pend <= 1'b1;
    end

  // R7
  stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> $past(cnt) == '0);
  // R10
  busy_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && stall));
  // R9
  err_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !stall);
  // R8
  rd_not_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !stall);
  // R3
  load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_load) |-> !busy && res_vld);
  // R4
  age_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({way_age[0] == '0 && way_vld[0], (NWAYS > 1) && way_age[NWAYS-1] == '0 && way_vld[NWAYS-1]}));
endmodule

// File: tb/tb_coproc_array_ctrl.sv
`timescale 1ns/1ps
module tb_coproc_array_ctrl;
  localparam int DW = 32, TW = 8, CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [TW-1:0] cmd_tag = 0;
  logic [CW-1:0] cmd_cnt = 0;
  logic [DW-1:0] cmd_a = 0, cmd_b = 0, arr_result = 0;
  logic busy, stall, cfg_load, arr_wr_en, rd_valid, err;
  logic [TW-1:0] cfg_tag;
  logic [DW-1:0] arr_a, arr_b, rd_data;

  coproc_array_ctrl dut (.clk, .rst_n, .cmd_valid, .cmd_op, .cmd_tag, .cmd_cnt,
    .cmd_a, .cmd_b, .arr_result, .busy, .stall, .cfg_load, .cfg_tag,
    .arr_wr_en, .arr_a, .arr_b, .rd_valid, .rd_data, .err);

  int errs = 0, checks = 0, cyc = 0;
  bit resident = 0;
  logic [TW-1:0] lru_q[$];
  always @(posedge clk) cyc++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [TW-1:0] t);
    foreach (lru_q[i]) if (lru_q[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void model_use(input logic [TW-1:0] t);
    for (int i = 0; i < lru_q.size(); i++)
      if (lru_q[i] == t) begin lru_q.delete(i); break; end
    if (lru_q.size() == 4) void'(lru_q.pop_back());
    lru_q.push_front(t);
  endfunction

  task automatic do_cfg(input logic [TW-1:0] t, input bit side);
    bit h = model_hit(t);
    int len = 0;
    @(negedge clk); cmd_valid = 1; cmd_op = 0; cmd_tag = t;
    @(negedge clk);
    if (side) begin cmd_op = 1; cmd_a = 32'hdead; end else cmd_valid = 0;
    while (busy && len < 100) begin
      chk(h ? "R2 cfg_load" : "R3 cfg_load", cfg_load, !h);
      chk("R3 cfg_tag", cfg_tag, t);
      if (side) chk("R10 write during busy", arr_wr_en, 0);
      len++;
      @(negedge clk); cmd_valid = 0;
    end
    chk(h ? "R2 R4 hit busy length" : "R3 R4 miss busy length", len, h ? 1 : 16);
    if (side) chk("R10 write after busy", arr_wr_en, 0);
    model_use(t);
    resident = 1;
  endtask

  task automatic do_start(input int n, input int side);
    int len = 0;
    logic [DW-1:0] v = $urandom;
    @(negedge clk); cmd_valid = 1; cmd_op = 3; cmd_cnt = CW'(n);
    @(negedge clk);
    if (!resident) begin
      cmd_valid = 0;
      chk("R9 err set", err, 1);
      chk("R9 no stall", stall, 0);
      return;
    end
    arr_result = v;
    case (side)
      1: cmd_op = 2;
      2: begin cmd_op = 1; cmd_a = 32'h55; end
      3: begin cmd_op = 0; cmd_tag = 8'h77; end
      default: cmd_valid = 0;
    endcase
    while (stall && len < 5000) begin
      chk("R8 no read during run", rd_valid, 0);
      chk("R10 no busy during run", busy, 0);
      chk("R10 no write during run", arr_wr_en, 0);
      len++;
      @(negedge clk); cmd_valid = 0;
    end
    chk("R7 stall length", len, n + 1);
    chk("R8 read after run", rd_valid, side == 1);
    if (side == 1) chk("R8 read data", rd_data, v);
    chk("R9 err clear", err, 0);
  endtask

  task automatic do_mt(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk); cmd_valid = 1; cmd_op = 1; cmd_a = a; cmd_b = b;
    @(negedge clk); cmd_valid = 0;
    chk("R5 write strobe", arr_wr_en, 1);
    chk("R5 operand a", arr_a, a);
    chk("R5 operand b", arr_b, b);
    @(negedge clk);
    chk("R5 single pulse", arr_wr_en, 0);
  endtask

  task automatic do_mf(input logic [DW-1:0] v);
    @(negedge clk); cmd_valid = 1; cmd_op = 2; arr_result = v;
    @(negedge clk); cmd_valid = 0; arr_result = ~v;
    chk("R6 read valid", rd_valid, 1);
    chk("R6 read data", rd_data, v);
    @(negedge clk);
    chk("R6 single pulse", rd_valid, 0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    wait (cyc > 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 stall in reset", stall, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 stall", stall, 0);
    chk("R1 cfg_load", cfg_load, 0);
    chk("R1 wr", arr_wr_en, 0);
    chk("R1 rd", rd_valid, 0);
    chk("R1 err", err, 0);

    do_start(5, 0);
    do_mt(32'h1, 32'h2);
    chk("R9 err cleared by next command", err, 0);

    // R4 directed replacement order
    do_cfg(1, 0); do_cfg(2, 0); do_cfg(3, 0); do_cfg(4, 0);
    do_cfg(1, 0); do_cfg(5, 0); do_cfg(2, 0); do_cfg(1, 0);
    do_cfg(3, 1); do_cfg(3, 1);

    do_start(0, 1);
    do_start(7, 1);
    do_start(3, 2);
    do_start(4, 3);
    do_start(0, 0);
    do_mf(32'hcafe_f00d);

    for (int k = 0; k < 80; k++) begin
      case ($urandom % 4)
        0: do_cfg(TW'($urandom % 6), 1'($urandom % 2));
        1: do_mt($urandom, $urandom);
        2: do_mf($urandom);
        default: do_start(int'($urandom % 20), int'($urandom % 4));
      endcase
    end
    report();
    $finish;
  end
endmodule